// File: doc/BRIEF.md
# Scan Gateway Instruction Decoder and Auxiliary Data Registers

This block sits beside the TAP controller of a scan-chain gateway. It reads the 8-bit instruction that the TAP holds and decides which small data register goes between the primary serial input and the primary serial output. The candidates are a one-bit bypass cell, a 32-bit identification word, a user code read from board pins, an 8-bit board status byte, a 3-bit register that enables the auto-write strobe on each downstream port, and two one-bit registers that issue command pulses. The boundary register lives outside this block. Here it is only selected and its serial output forwarded.

The TAP controller supplies one-cycle state levels: reset state, Capture-IR, Capture-DR, Shift-DR and Update-DR. Each register loads its captured value at Capture-DR and shifts right during Shift-DR. Serial input enters at the most significant bit and the least significant bit is presented on `dr_tdo`. The two pulse registers let a tester start a self-test on a remote board, or reset the devices behind the downstream ports. A low pulse lasting exactly the Update-DR cycle does this without touching the gateway's own reset, so the gateway stays selected and keeps its configuration.

Top module: `gw_aux_regs`

## Requirements
- R1: The instruction picks the data register as follows. 0xFF and 0x88 pick bypass. 0x00 and 0x81 pick the external boundary register. 0xAA picks identification. 0x97 picks user code. 0x98 picks auto-write. 0x99 picks self-test. 0x9A picks status. 0x9B picks port reset. Every other code picks identification.
- R2: The identification register holds 0x0001036F. Bits [11:0] are the maker, bits [27:12] the part and bits [31:28] the revision. It reloads this value after reset, in the reset state, at Capture-IR, and at Capture-DR when it is selected.
- R3: The bypass cell captures 0 and adds exactly one cycle of delay from `tdi` to `dr_tdo`.
- R4: With 0x97, Capture-DR loads the user code pins and shifts them out LSB first.
- R5: The status register samples the status pins at every Capture-DR, in positive logic, and shifts them out LSB first when 0x9A is selected.
- R6: During Shift-DR the selected register shifts right by one bit per cycle, `tdi` entering at its MSB. After W shifts, bits shifted in come out of a W-bit register.
- R7: The auto-write register takes its shifted value at Update-DR when 0x98 is selected. Bit k enables port k+1: `port_aw_oe[k]` follows the bit, and `port_aw[k]` carries `prim_autowr` while the port is enabled and 0 while it is disabled. Capture-DR reads back the current value.
- R8: The auto-write register clears on `trst_n` low and on any clock cycle in the reset state.
- R9: With 0x99, Capture-DR clears the self-test bit. If the bit is still 0 at Update-DR, `self_test_n` is low for exactly that Update-DR cycle. A 1 shifted into the bit suppresses the pulse.
- R10: With 0x9B the same rule drives every bit of `port_trst_n` low together for the Update-DR cycle. The auto-write configuration is unchanged.
- R11: `self_test_n` and `port_trst_n` stay high outside the Update-DR cycle of their own instruction.
- R12: `bsr_sel` is high exactly when the boundary register is picked. While it is high, `dr_tdo` follows `bsr_so`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr | input | 1 | TAP is in the reset state |
| capture_ir | input | 1 | TAP is in Capture-IR |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| ir | input | 8 | Current instruction |
| tdi | input | 1 | Primary serial data in |
| bsr_so | input | 1 | Serial output of the external boundary register |
| usercode_pins | input | UC_W (32) | User code board pins |
| status_pins | input | ST_W (8) | Board status pins |
| prim_autowr | input | 1 | Primary auto-write strobe |
| dr_tdo | output | 1 | Serial output of the selected data register |
| bsr_sel | output | 1 | Boundary register selected |
| self_test_n | output | 1 | Self-test pulse, active low |
| port_trst_n | output | NPORT (3) | Downstream port reset pulses, active low |
| port_aw | output | NPORT (3) | Auto-write strobe per port |
| port_aw_oe | output | NPORT (3) | Output enable per port strobe (0 = high impedance) |

## Verification
The bench first checks a shift longer than the register. A design that dropped `tdi` at the wrong end would return a rotated word instead of the input bits. It then checks that a self-test or port-reset scan with a 1 shifted into the command bit produces no pulse. A design that pulsed on selection alone would reset boards the tester meant to leave alone.

It also checks that the identification word reloads at Capture-IR. A design that reloaded it only at Capture-DR would return stale data. The port-reset pulse must leave the auto-write enables intact, and the reset state must clear them. Undefined opcodes must fall back to identification, and the alias opcode must select bypass. Random instruction and pin patterns are checked against a bench model of decode, capture and update.

// File: rtl/gw_aux_pkg.sv
package gw_aux_pkg;

  typedef enum logic [2:0] {
    SEL_BYP   = 3'd0,
    SEL_BSR   = 3'd1,
    SEL_ID    = 3'd2,
    SEL_UC    = 3'd3,
    SEL_STAT  = 3'd4,
    SEL_AW    = 3'd5,
    SEL_STEST = 3'd6,
    SEL_LRST  = 3'd7
  } dr_sel_e;

  localparam int unsigned NUM_SEL = 8;

  localparam logic [7:0] OPC_BYPASS   = 8'hFF;
  localparam logic [7:0] OPC_EXTEST   = 8'h00;
  localparam logic [7:0] OPC_SAMPLE   = 8'h81;
  localparam logic [7:0] OPC_IDCODE   = 8'hAA;
  localparam logic [7:0] OPC_SOFTRST  = 8'h88;
  localparam logic [7:0] OPC_USERCODE = 8'h97;
  localparam logic [7:0] OPC_AUTOWR   = 8'h98;
  localparam logic [7:0] OPC_STEST    = 8'h99;
  localparam logic [7:0] OPC_STATUS   = 8'h9A;
  localparam logic [7:0] OPC_LRST     = 8'h9B;

  localparam logic [3:0]  ID_REV   = 4'h0;
  localparam logic [15:0] ID_PART  = 16'h0010;
  localparam logic [11:0] ID_MAKER = 12'h36F;

  function automatic logic [31:0] id_word();
    return {ID_REV, ID_PART, ID_MAKER};
  endfunction

  function automatic dr_sel_e decode_ir(input logic [7:0] op);
    dr_sel_e s;
    case (op)
      OPC_BYPASS, OPC_SOFTRST: s = SEL_BYP;
      OPC_EXTEST, OPC_SAMPLE:  s = SEL_BSR;
      OPC_USERCODE:            s = SEL_UC;
      OPC_AUTOWR:              s = SEL_AW;
      OPC_STEST:               s = SEL_STEST;
      OPC_STATUS:              s = SEL_STAT;
      OPC_LRST:                s = SEL_LRST;
      default:                 s = SEL_ID;
    endcase
    return s;
  endfunction

  // A pulse fires when its register is selected at Update-DR and its bit is still clear
  function automatic logic pulse_fire(input logic upd, input logic picked, input logic bitv);
    return upd & picked & ~bitv;
  endfunction

endpackage

// File: rtl/gw_ir_decode.sv
module gw_ir_decode
  import gw_aux_pkg::*;
(
  input  logic [7:0]         ir,
  output dr_sel_e            sel,
  output logic [NUM_SEL-1:0] sel_oh
);
  assign sel = decode_ir(ir);

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_oh
    assign sel_oh[k] = (sel == dr_sel_e'(k));
  end
endmodule

// File: rtl/gw_dr_cell.sv
module gw_dr_cell #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         si,
  output logic [W-1:0] q
);
  if (W == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST_VAL;
      else if (load)  q <= load_val;
      else if (shift) q <= si;
    end
  end else begin : g_multi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST_VAL;
      else if (load)  q <= load_val;
      else if (shift) q <= {si, q[W-1:1]};
    end
  end
endmodule

// File: rtl/gw_pulse_gen.sv
module gw_pulse_gen #(
  parameter int unsigned N = 1
) (
  input  logic         fire,
  output logic [N-1:0] pulse_n
);
  for (genvar i = 0; i < N; i++) begin : g_out
    assign pulse_n[i] = ~fire;
  end
endmodule

// File: rtl/gw_aux_regs.sv
module gw_aux_regs
  import gw_aux_pkg::*;
#(
  parameter int unsigned UC_W  = 32,
  parameter int unsigned ST_W  = 8,
  parameter int unsigned NPORT = 3
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tlr,
  input  logic             capture_ir,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic [7:0]       ir,
  input  logic             tdi,
  input  logic             bsr_so,
  input  logic [UC_W-1:0]  usercode_pins,
  input  logic [ST_W-1:0]  status_pins,
  input  logic             prim_autowr,
  output logic             dr_tdo,
  output logic             bsr_sel,
  output logic             self_test_n,
  output logic [NPORT-1:0] port_trst_n,
  output logic [NPORT-1:0] port_aw,
  output logic [NPORT-1:0] port_aw_oe
);
  localparam int unsigned ID_W = 32;

  dr_sel_e            sel;
  logic [NUM_SEL-1:0] sel_oh;

  gw_ir_decode u_dec (.ir(ir), .sel(sel), .sel_oh(sel_oh));

  // Per-register capture and shift strobes
  logic [NUM_SEL-1:0] cap_en, shf_en;
  assign cap_en = {NUM_SEL{capture_dr}} & sel_oh;
  assign shf_en = {NUM_SEL{shift_dr}} & sel_oh;

  logic             byp_q, stest_q, lrst_q;
  logic [ID_W-1:0]  id_q;
  logic [UC_W-1:0]  uc_q;
  logic [ST_W-1:0]  st_q;
  logic [NPORT-1:0] aw_sh, aw_q;
  logic             id_load;

  assign id_load = tlr | capture_ir | cap_en[SEL_ID];

  gw_dr_cell #(.W(1), .RST_VAL(1'b0)) u_byp (
    .clk(tck), .rst_n(trst_n), .load(cap_en[SEL_BYP]), .load_val(1'b0),
    .shift(shf_en[SEL_BYP]), .si(tdi), .q(byp_q));

  gw_dr_cell #(.W(ID_W), .RST_VAL(id_word())) u_id (
    .clk(tck), .rst_n(trst_n), .load(id_load), .load_val(id_word()),
    .shift(shf_en[SEL_ID]), .si(tdi), .q(id_q));

  gw_dr_cell #(.W(UC_W), .RST_VAL('0)) u_uc (
    .clk(tck), .rst_n(trst_n), .load(cap_en[SEL_UC]), .load_val(usercode_pins),
    .shift(shf_en[SEL_UC]), .si(tdi), .q(uc_q));

  // Status samples at every Capture-DR, shifts only when picked
  gw_dr_cell #(.W(ST_W), .RST_VAL('0)) u_st (
    .clk(tck), .rst_n(trst_n), .load(capture_dr), .load_val(status_pins),
    .shift(shf_en[SEL_STAT]), .si(tdi), .q(st_q));

  gw_dr_cell #(.W(NPORT), .RST_VAL('0)) u_aw (
    .clk(tck), .rst_n(trst_n), .load(cap_en[SEL_AW]), .load_val(aw_q),
    .shift(shf_en[SEL_AW]), .si(tdi), .q(aw_sh));

  gw_dr_cell #(.W(1), .RST_VAL(1'b1)) u_stest (
    .clk(tck), .rst_n(trst_n), .load(cap_en[SEL_STEST]), .load_val(1'b0),
    .shift(shf_en[SEL_STEST]), .si(tdi), .q(stest_q));

  gw_dr_cell #(.W(1), .RST_VAL(1'b1)) u_lrst (
    .clk(tck), .rst_n(trst_n), .load(cap_en[SEL_LRST]), .load_val(1'b0),
    .shift(shf_en[SEL_LRST]), .si(tdi), .q(lrst_q));

  // Auto-write update register
  logic aw_commit;
  assign aw_commit = update_dr & sel_oh[SEL_AW];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        aw_q <= '0;
    else if (tlr)       aw_q <= '0;
    else if (aw_commit) aw_q <= aw_sh;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_aw
    assign port_aw_oe[p] = aw_q[p];
    assign port_aw[p]    = aw_q[p] & prim_autowr;
  end

  // Command pulses
  logic stest_fire, lrst_fire;
  assign stest_fire = pulse_fire(update_dr, sel_oh[SEL_STEST], stest_q);
  assign lrst_fire  = pulse_fire(update_dr, sel_oh[SEL_LRST], lrst_q);

  gw_pulse_gen #(.N(1))     u_pst (.fire(stest_fire), .pulse_n(self_test_n));
  gw_pulse_gen #(.N(NPORT)) u_prt (.fire(lrst_fire),  .pulse_n(port_trst_n));

  // Serial output mux
  always_comb begin
    case (sel)
      SEL_BYP:   dr_tdo = byp_q;
      SEL_BSR:   dr_tdo = bsr_so;
      SEL_ID:    dr_tdo = id_q[0];
      SEL_UC:    dr_tdo = uc_q[0];
      SEL_STAT:  dr_tdo = st_q[0];
      SEL_AW:    dr_tdo = aw_sh[0];
      SEL_STEST: dr_tdo = stest_q;
      SEL_LRST:  dr_tdo = lrst_q;
      default:   dr_tdo = 1'b0;
    endcase
  end

  assign bsr_sel = sel_oh[SEL_BSR];
endmodule

// File: rtl/gw_aux_regs_chk.sv
module gw_aux_regs_chk #(
  parameter int unsigned NPORT = 3
) (
  input logic             tck,
  input logic             trst_n,
  input logic             tlr,
  input logic             capture_dr,
  input logic             update_dr,
  input logic [7:0]       ir,
  input logic             dr_tdo,
  input logic             bsr_sel,
  input logic             self_test_n,
  input logic [NPORT-1:0] port_trst_n,
  input logic [NPORT-1:0] port_aw_oe
);
  // R9
  stest_in_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !self_test_n |-> update_dr);

  // R11
  stest_idle_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir != 8'h99) |-> self_test_n);

  // R11
  lrst_idle_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir != 8'h9B) |-> (&port_trst_n));

  // R10
  lrst_together_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (&port_trst_n) || !(|port_trst_n));

  // R8
  aw_clear_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tlr |=> (port_aw_oe == '0));

  // R7
  aw_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!update_dr && !tlr) |=> $stable(port_aw_oe));

  // R12
  bsr_decode_chk: assert property (@(posedge tck) disable iff (!trst_n)
    bsr_sel |-> (ir == 8'h00 || ir == 8'h81));

  // R3
  byp_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && ir == 8'hFF) |=> (ir != 8'hFF) || !dr_tdo);
endmodule

bind gw_aux_regs gw_aux_regs_chk #(.NPORT(NPORT)) u_chk (
  .tck(tck), .trst_n(trst_n), .tlr(tlr), .capture_dr(capture_dr),
  .update_dr(update_dr), .ir(ir), .dr_tdo(dr_tdo), .bsr_sel(bsr_sel),
  .self_test_n(self_test_n), .port_trst_n(port_trst_n), .port_aw_oe(port_aw_oe));

// File: tb/tb_gw_aux_regs.sv
`timescale 1ns/1ps
module tb_gw_aux_regs;
  logic        tck = 0, trst_n = 0, tlr = 0, capture_ir = 0, capture_dr = 0;
  logic        shift_dr = 0, update_dr = 0, tdi = 0, bsr_so = 0, prim_autowr = 0;
  logic [7:0]  ir = 8'hAA;
  logic [31:0] usercode_pins = 0;
  logic [7:0]  status_pins = 0;
  logic        dr_tdo, bsr_sel, self_test_n;
  logic [2:0]  port_trst_n, port_aw, port_aw_oe;

  int n_chk = 0, n_fail = 0;
  logic [2:0] aw_model = 0;

  gw_aux_regs dut (.*);

  always #5 tck = ~tck;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  task automatic cyc();
    @(posedge tck); @(negedge tck);
  endtask

  // Bench-side model of the instruction map (R1)
  function automatic int exp_len(input logic [7:0] op);
    case (op)
      8'hFF, 8'h88, 8'h99, 8'h9B: return 1;
      8'h00, 8'h81: return 8;
      8'h97: return 32;
      8'h98: return 3;
      8'h9A: return 8;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] exp_cap(input logic [7:0] op, input logic [31:0] din);
    case (op)
      8'hFF, 8'h88, 8'h99, 8'h9B: return 32'h0;
      8'h00, 8'h81: return ~din;
      8'h97: return usercode_pins;
      8'h98: return {29'h0, aw_model};
      8'h9A: return {24'h0, status_pins};
      default: return 32'h0001036F;
    endcase
  endfunction

  function automatic logic [31:0] lenmask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
  endfunction

  // Capture, shift len bits of din, update; returns the bits seen and pulses seen at update
  task automatic scan(input logic [7:0] op, input logic [31:0] din, input int len, input bit do_cap,
                      output logic [63:0] got, output logic st_n, output logic [2:0] tr_n,
                      output logic bs);
    got = '0;
    ir = op;
    if (do_cap) begin capture_dr = 1; cyc(); capture_dr = 0; end
    shift_dr = 1;
    for (int i = 0; i < len; i++) begin
      tdi = din[i % 32];
      bsr_so = ~din[i % 32];
      #1;
      got[i] = dr_tdo;
      if (!self_test_n || port_trst_n != 3'b111) begin
        n_chk++; n_fail++;
        $display("FAIL R11 actual=pulse_in_shift expected=idle");
      end
      cyc();
    end
    shift_dr = 0;
    update_dr = 1;
    #1;
    st_n = self_test_n; tr_n = port_trst_n; bs = bsr_sel;
    cyc();
    update_dr = 0;
    #1;
    chk(self_test_n && port_trst_n == 3'b111, "R11", {self_test_n, port_trst_n}, 4'hF);
  endtask

  logic [63:0] g;
  logic        s_n, b;
  logic [2:0]  t_n;
  logic [7:0]  ops [12] = '{8'hFF, 8'h00, 8'h81, 8'hAA, 8'h88, 8'h97, 8'h98, 8'h99,
                           8'h9A, 8'h9B, 8'h3C, 8'hE7};

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge tck); @(negedge tck);
    #1;
    chk(dr_tdo == 1'b1, "R2 reset lsb", dr_tdo, 1);
    chk(self_test_n && port_trst_n == 3'b111, "R11 reset idle", {self_test_n, port_trst_n}, 4'hF);
    chk(port_aw_oe == 0, "R8 reset", port_aw_oe, 0);
    trst_n = 1;
    cyc();

    // R2 identification
    scan(8'hAA, 32'h0, 32, 1, g, s_n, t_n, b);
    chk(g[31:0] == 32'h0001036F, "R2 idcode", g[31:0], 32'h0001036F);

    // R6 long shift: input bits emerge after 32 cycles
    scan(8'hAA, 32'hA5C3_0F96, 40, 1, g, s_n, t_n, b);
    chk(g[39:32] == 8'h96, "R6 pass-through bits", g[39:32], 8'h96);

    // R2 Capture-IR reload without Capture-DR
    scan(8'hAA, 32'h0, 32, 1, g, s_n, t_n, b);
    capture_ir = 1; cyc(); capture_ir = 0;
    scan(8'hAA, 32'h0, 32, 0, g, s_n, t_n, b);
    chk(g[31:0] == 32'h0001036F, "R2 capture-ir reload", g[31:0], 32'h0001036F);

    // R3 bypass one-cycle delay
    scan(8'hFF, 32'h3, 2, 1, g, s_n, t_n, b);
    chk(g[1:0] == 2'b10, "R3 bypass", g[1:0], 2'b10);

    // R1 alias and undefined codes
    scan(8'h88, 32'h1, 2, 1, g, s_n, t_n, b);
    chk(g[1:0] == 2'b10, "R1 alias bypass", g[1:0], 2'b10);
    scan(8'h5C, 32'h0, 32, 1, g, s_n, t_n, b);
    chk(g[31:0] == 32'h0001036F, "R1 undefined->id", g[31:0], 32'h0001036F);

    // R4 user code, R5 status
    usercode_pins = 32'hDEAD_B00F; status_pins = 8'h6B;
    scan(8'h97, 32'h0, 32, 1, g, s_n, t_n, b);
    chk(g[31:0] == 32'hDEAD_B00F, "R4 usercode", g[31:0], 32'hDEAD_B00F);
    scan(8'h9A, 32'h0, 8, 1, g, s_n, t_n, b);
    chk(g[7:0] == 8'h6B, "R5 status", g[7:0], 8'h6B);

    // R7 auto-write
    scan(8'h98, 32'h5, 3, 1, g, s_n, t_n, b);
    aw_model = 3'b101;
    chk(port_aw_oe == 3'b101, "R7 oe", port_aw_oe, 3'b101);
    prim_autowr = 1; #1;
    chk(port_aw == 3'b101, "R7 strobe", port_aw, 3'b101);
    prim_autowr = 0; #1;
    chk(port_aw == 3'b000, "R7 strobe low", port_aw, 3'b000);
    scan(8'h98, 32'h5, 3, 1, g, s_n, t_n, b);
    chk(g[2:0] == 3'b101, "R7 readback", g[2:0], 3'b101);

    // R9 self-test pulse and suppression
    scan(8'h99, 32'h0, 1, 1, g, s_n, t_n, b);
    chk(s_n == 1'b0, "R9 pulse", s_n, 0);
    scan(8'h99, 32'h1, 1, 1, g, s_n, t_n, b);
    chk(s_n == 1'b1, "R9 suppressed", s_n, 1);

    // R10 port reset pulse keeps configuration
    scan(8'h9B, 32'h0, 1, 1, g, s_n, t_n, b);
    chk(t_n == 3'b000, "R10 pulse", t_n, 3'b000);
    chk(port_aw_oe == 3'b101, "R10 config kept", port_aw_oe, 3'b101);
    scan(8'h9B, 32'h1, 1, 1, g, s_n, t_n, b);
    chk(t_n == 3'b111, "R10 suppressed", t_n, 3'b111);

    // R12 boundary pick
    scan(8'h00, 32'h96, 8, 1, g, s_n, t_n, b);
    chk(b == 1'b1 && g[7:0] == 8'h69, "R12 boundary", {b, g[7:0]}, {1'b1, 8'h69});
    scan(8'hAA, 32'h0, 1, 1, g, s_n, t_n, b);
    chk(b == 1'b0, "R12 not boundary", b, 0);

    // R8 reset state and trst_n clear
    tlr = 1; cyc(); tlr = 0; #1;
    chk(port_aw_oe == 0, "R8 tlr clear", port_aw_oe, 0);
    aw_model = 0;
    scan(8'h98, 32'h7, 3, 1, g, s_n, t_n, b);
    aw_model = 3'b111;
    trst_n = 0; #2; trst_n = 1; #1;
    chk(port_aw_oe == 0, "R8 trst clear", port_aw_oe, 0);
    aw_model = 0;
    cyc();

    // Random mix
    for (int it = 0; it < 300; it++) begin
      logic [7:0]  op;
      logic [31:0] din, exp;
      int          len;
      op = ops[$urandom % 12];
      if ($urandom % 6 == 0) op = 8'($urandom);
      din = $urandom;
      usercode_pins = $urandom;
      status_pins = 8'($urandom);
      prim_autowr = 1'($urandom);
      len = exp_len(op);
      exp = exp_cap(op, din) & lenmask(len);
      scan(op, din, len, 1, g, s_n, t_n, b);
      chk((g[31:0] & lenmask(len)) == exp, "R1 R4 R5 random capture", g[31:0] & lenmask(len), exp);
      chk(s_n == !(op == 8'h99 && din[0] == 1'b0), "R9 random", s_n, !(op == 8'h99 && din[0] == 1'b0));
      chk(t_n == ((op == 8'h9B && din[0] == 1'b0) ? 3'b000 : 3'b111), "R10 random", t_n,
          (op == 8'h9B && din[0] == 1'b0) ? 3'b000 : 3'b111);
      if (op == 8'h98) aw_model = din[2:0];
      chk(port_aw_oe == aw_model, "R7 random oe", port_aw_oe, aw_model);
      chk(port_aw == (aw_model & {3{prim_autowr}}), "R7 random strobe", port_aw,
          aw_model & {3{prim_autowr}});
    end

    summary();
  end
endmodule